// File: doc/BRIEF.md
# Flash Block Age and Dwell Tracker

This block keeps wear and timing metadata for every erase block of a flash array, for use by a controller that picks read reference voltages. Each time a block is programmed, the block records the current value of a free-running time counter as that block's write stamp and advances the block's program/erase count. From the second program onward, it also measures the idle gap since the previous program of the same block and pushes it into a bounded per-block history that keeps only the most recent gaps.

On a read request, the block answers one cycle later with four values for the addressed block. These are the elapsed time since its last program, its program/erase count, how many gap samples it holds, and the mean of those samples. A voltage prediction stage downstream consumes these values. The mean comes from a running sum and a reciprocal multiply, so no divider sits in the path. Timestamp arithmetic is modulo the counter width.

Top module: `blk_age_tracker`

## Requirements
- R1: After reset no response is pending, and a read of a block not programmed since reset returns zero age, zero count, zero samples and zero mean.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `rd_valid` high, and low after a cycle with `rd_valid` low.
- R3: A program stores `now_ts` as the block's write stamp, and the reported age is `(now_ts at the read) - stamp` modulo 2^TS_W, which is correct across one counter wrap.
- R4: Each program adds one to the block's count, which saturates at 2^PEC_W-1.
- R5: The first program of a block after reset adds no gap sample.
- R6: Every later program adds a sample equal to `now_ts` minus the previous write stamp of that block, modulo 2^TS_W.
- R7: A block holds at most DEPTH samples. Once the history is full, a new sample replaces the oldest one and the reported sample count stays at DEPTH.
- R8: The reported mean is floor(sum of held samples / sample count), or zero when the count is zero.
- R9: When a program and a read target the same block in one cycle, the program is applied first. The read then reports age zero together with the updated count, sample count and mean.
- R10: A program of one block leaves every other block's reported values unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| now_ts | input | TS_W | Free-running time counter value |
| prog_valid | input | 1 | Program of block `prog_blk` this cycle |
| prog_blk | input | IDX_W | Index of the programmed block |
| rd_valid | input | 1 | Metadata request for block `rd_blk` |
| rd_blk | input | IDX_W | Index of the requested block |
| rsp_valid | output | 1 | Response fields are valid |
| rsp_age | output | TS_W | Time since the block's last program |
| rsp_pec | output | PEC_W | Program/erase count of the block |
| rsp_dwell_cnt | output | CNT_W | Number of held gap samples |
| rsp_dwell_mean | output | TS_W | Mean of the held gap samples |

## Verification
A program and a read can land on the same block in the same cycle. The bench provokes this by raising both strobes with equal indices. It judges the response against a reference model in which the program has already been applied: age zero, the incremented count, and the gap history including the new sample. It also raises both strobes with different indices, to confirm that the read then sees only its own block's unchanged values.

// File: rtl/bat_pkg.sv
package bat_pkg;

    localparam int unsigned BAT_BLOCKS_DFLT = 8;
    localparam int unsigned BAT_TS_W_DFLT   = 16;
    localparam int unsigned BAT_PEC_W_DFLT  = 16;
    localparam int unsigned BAT_DEPTH_DFLT  = 20;

    // ceil(2^frac / n); with frac large enough, (x * result) >> frac == floor(x / n)
    function automatic logic [63:0] bat_recip(input int unsigned n, input int unsigned frac);
        if (n == 0) begin
            return 64'd0;
        end
        return ((64'd1 << frac) + 64'(n) - 64'd1) / 64'(n);
    endfunction

endpackage

// File: rtl/bat_dwell_ring.sv
module bat_dwell_ring #(
    parameter  int unsigned DEPTH = 20,
    parameter  int unsigned TS_W  = 16,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1),
    localparam int unsigned SUM_W = TS_W + $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [TS_W-1:0]  sample_i,
    output logic [SUM_W-1:0] sum_nx_o,
    output logic [CNT_W-1:0] cnt_nx_o
);

    typedef struct packed {
        logic [DEPTH-1:0][TS_W-1:0] hist;
        logic [PTR_W-1:0]           ptr;
        logic [CNT_W-1:0]           cnt;
        logic [SUM_W-1:0]           sum;
    } ring_t;

    ring_t            ring_d, ring_q;
    logic [TS_W-1:0]  evict;
    logic             full;

    always_comb begin
        ring_d = ring_q;
        full   = (ring_q.cnt == CNT_W'(DEPTH));
        evict  = '0;
        if (push_i) begin
            if (full) begin
                evict = ring_q.hist[ring_q.ptr];
            end
            ring_d.hist[ring_q.ptr] = sample_i;
            ring_d.sum = ring_q.sum - SUM_W'(evict) + SUM_W'(sample_i);
            if (ring_q.ptr == PTR_W'(DEPTH - 1)) begin
                ring_d.ptr = '0;
            end else begin
                ring_d.ptr = ring_q.ptr + PTR_W'(1);
            end
            if (!full) begin
                ring_d.cnt = ring_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ring_q <= '0;
        end else begin
            ring_q <= ring_d;
        end
    end

    // Next-state view so a read in the same cycle as a push sees the push
    assign sum_nx_o = ring_d.sum;
    assign cnt_nx_o = ring_d.cnt;

endmodule

// File: rtl/bat_mean_unit.sv
module bat_mean_unit
    import bat_pkg::*;
#(
    parameter  int unsigned DEPTH = 20,
    parameter  int unsigned TS_W  = 16,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1),
    localparam int unsigned SUM_W = TS_W + $clog2(DEPTH),
    localparam int unsigned FRAC  = SUM_W + CNT_W,
    localparam int unsigned RCP_W = FRAC + 1,
    localparam int unsigned PRD_W = SUM_W + RCP_W
) (
    input  logic [SUM_W-1:0] sum_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [TS_W-1:0]  mean_o
);

    logic [DEPTH:0][RCP_W-1:0] rcp_tab;

    for (genvar n = 0; n <= DEPTH; n++) begin : g_rcp
        localparam logic [63:0] RV = bat_recip(n, FRAC);
        assign rcp_tab[n] = RV[RCP_W-1:0];
    end

    logic [RCP_W-1:0] rcp_sel;
    logic [PRD_W-1:0] prod;
    logic [PRD_W-1:0] quot;

    always_comb begin
        rcp_sel = '0;
        for (int n = 0; n <= DEPTH; n++) begin
            if (cnt_i == CNT_W'(n)) begin
                rcp_sel = rcp_tab[n];
            end
        end
        prod   = PRD_W'(sum_i) * PRD_W'(rcp_sel);
        quot   = prod >> FRAC;
        mean_o = quot[TS_W-1:0];
    end

endmodule

// File: rtl/blk_age_tracker.sv
module blk_age_tracker
    import bat_pkg::*;
#(
    parameter  int unsigned NUM_BLOCKS = BAT_BLOCKS_DFLT,
    parameter  int unsigned TS_W       = BAT_TS_W_DFLT,
    parameter  int unsigned PEC_W      = BAT_PEC_W_DFLT,
    parameter  int unsigned DEPTH      = BAT_DEPTH_DFLT,
    localparam int unsigned IDX_W      = $clog2(NUM_BLOCKS),
    localparam int unsigned CNT_W      = $clog2(DEPTH + 1),
    localparam int unsigned SUM_W      = TS_W + $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TS_W-1:0]  now_ts,
    input  logic             prog_valid,
    input  logic [IDX_W-1:0] prog_blk,
    input  logic             rd_valid,
    input  logic [IDX_W-1:0] rd_blk,
    output logic             rsp_valid,
    output logic [TS_W-1:0]  rsp_age,
    output logic [PEC_W-1:0] rsp_pec,
    output logic [CNT_W-1:0] rsp_dwell_cnt,
    output logic [TS_W-1:0]  rsp_dwell_mean
);

    typedef struct packed {
        logic             seen;
        logic [PEC_W-1:0] pec;
        logic [TS_W-1:0]  stamp;
    } meta_t;

    typedef struct packed {
        meta_t [NUM_BLOCKS-1:0] blk;
        logic                   rv;
        logic [TS_W-1:0]        age;
        logic [PEC_W-1:0]       pec;
        logic [CNT_W-1:0]       cnt;
        logic [TS_W-1:0]        mean;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_BLOCKS-1:0]            push;
    logic [TS_W-1:0]                  gap;
    logic [NUM_BLOCKS-1:0][SUM_W-1:0] sum_nx;
    logic [NUM_BLOCKS-1:0][CNT_W-1:0] cnt_nx;
    logic [SUM_W-1:0]                 rd_sum;
    logic [CNT_W-1:0]                 rd_cnt;
    logic [TS_W-1:0]                  rd_mean;
    meta_t                            rd_meta;

    // Gap since the previous program; only pushed once the block has a stamp
    always_comb begin
        gap = now_ts - st_q.blk[prog_blk].stamp;
        for (int b = 0; b < NUM_BLOCKS; b++) begin
            push[b] = prog_valid && (prog_blk == IDX_W'(b)) && st_q.blk[b].seen;
        end
    end

    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
        bat_dwell_ring #(
            .DEPTH (DEPTH),
            .TS_W  (TS_W)
        ) u_ring (
            .clk      (clk),
            .rst_n    (rst_n),
            .push_i   (push[b]),
            .sample_i (gap),
            .sum_nx_o (sum_nx[b]),
            .cnt_nx_o (cnt_nx[b])
        );
    end

    assign rd_sum = sum_nx[rd_blk];
    assign rd_cnt = cnt_nx[rd_blk];

    bat_mean_unit #(
        .DEPTH (DEPTH),
        .TS_W  (TS_W)
    ) u_mean (
        .sum_i  (rd_sum),
        .cnt_i  (rd_cnt),
        .mean_o (rd_mean)
    );

    always_comb begin
        st_d = st_q;
        // Program first, so a read of the same block sees the update
        if (prog_valid) begin
            st_d.blk[prog_blk].stamp = now_ts;
            st_d.blk[prog_blk].seen  = 1'b1;
            if (st_q.blk[prog_blk].pec != {PEC_W{1'b1}}) begin
                st_d.blk[prog_blk].pec = st_q.blk[prog_blk].pec + PEC_W'(1);
            end
        end
        rd_meta = st_d.blk[rd_blk];
        st_d.rv = rd_valid;
        if (rd_valid) begin
            st_d.age  = rd_meta.seen ? (now_ts - rd_meta.stamp) : '0;
            st_d.pec  = rd_meta.pec;
            st_d.cnt  = rd_cnt;
            st_d.mean = rd_mean;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid      = st_q.rv;
    assign rsp_age        = st_q.age;
    assign rsp_pec        = st_q.pec;
    assign rsp_dwell_cnt  = st_q.cnt;
    assign rsp_dwell_mean = st_q.mean;

endmodule

// File: rtl/blk_age_tracker_chk.sv
module blk_age_tracker_chk #(
    parameter int unsigned IDX_W = 3,
    parameter int unsigned TS_W  = 16,
    parameter int unsigned PEC_W = 16,
    parameter int unsigned CNT_W = 5,
    parameter int unsigned DEPTH = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             prog_valid,
    input logic [IDX_W-1:0] prog_blk,
    input logic             rd_valid,
    input logic [IDX_W-1:0] rd_blk,
    input logic             rsp_valid,
    input logic [TS_W-1:0]  rsp_age,
    input logic [PEC_W-1:0] rsp_pec,
    input logic [CNT_W-1:0] rsp_dwell_cnt,
    input logic [TS_W-1:0]  rsp_dwell_mean
);

    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |=> rsp_valid); // R2
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n) !rd_valid |=> !rsp_valid); // R2
    AST_SAME_CYCLE_AGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (rd_valid && prog_valid && rd_blk == prog_blk) |=> (rsp_age == '0 && rsp_pec != '0)); // R9
    AST_HISTORY_BOUND: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> rsp_dwell_cnt <= CNT_W'(DEPTH)); // R7
    AST_EMPTY_MEAN_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && rsp_dwell_cnt == '0) |-> rsp_dwell_mean == '0); // R8
    AST_UNPROGRAMMED_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && rsp_pec == '0) |-> (rsp_age == '0 && rsp_dwell_cnt == '0)); // R1
    AST_FIRST_PROG_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && rsp_pec == PEC_W'(1)) |-> rsp_dwell_cnt == '0); // R5

endmodule

bind blk_age_tracker blk_age_tracker_chk #(
    .IDX_W (IDX_W),
    .TS_W  (TS_W),
    .PEC_W (PEC_W),
    .CNT_W (CNT_W),
    .DEPTH (DEPTH)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .prog_valid     (prog_valid),
    .prog_blk       (prog_blk),
    .rd_valid       (rd_valid),
    .rd_blk         (rd_blk),
    .rsp_valid      (rsp_valid),
    .rsp_age        (rsp_age),
    .rsp_pec        (rsp_pec),
    .rsp_dwell_cnt  (rsp_dwell_cnt),
    .rsp_dwell_mean (rsp_dwell_mean)
);

// File: tb/blk_age_tracker_bench.sv
module blk_age_tracker_bench;

    localparam int unsigned NB    = 8;
    localparam int unsigned TS_W  = 16;
    localparam int unsigned PEC_W = 5;
    localparam int unsigned DEPTH = 20;
    localparam int unsigned IDX_W = 3;
    localparam int unsigned CNT_W = 5;
    localparam int unsigned MASK  = 32'h0000_FFFF;
    localparam int unsigned PMAX  = 31;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [TS_W-1:0]  now_ts = '0;
    logic             prog_valid = 1'b0;
    logic [IDX_W-1:0] prog_blk = '0;
    logic             rd_valid = 1'b0;
    logic [IDX_W-1:0] rd_blk = '0;
    logic             rsp_valid;
    logic [TS_W-1:0]  rsp_age;
    logic [PEC_W-1:0] rsp_pec;
    logic [CNT_W-1:0] rsp_dwell_cnt;
    logic [TS_W-1:0]  rsp_dwell_mean;

    always #5 clk = ~clk;

    blk_age_tracker #(
        .NUM_BLOCKS (NB),
        .TS_W       (TS_W),
        .PEC_W      (PEC_W),
        .DEPTH      (DEPTH)
    ) u_blk_age_tracker (
        .clk            (clk),
        .rst_n          (rst_n),
        .now_ts         (now_ts),
        .prog_valid     (prog_valid),
        .prog_blk       (prog_blk),
        .rd_valid       (rd_valid),
        .rd_blk         (rd_blk),
        .rsp_valid      (rsp_valid),
        .rsp_age        (rsp_age),
        .rsp_pec        (rsp_pec),
        .rsp_dwell_cnt  (rsp_dwell_cnt),
        .rsp_dwell_mean (rsp_dwell_mean)
    );

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // Reference model built from the requirements
    int unsigned m_stamp [NB];
    int unsigned m_pec   [NB];
    bit          m_seen  [NB];
    int unsigned m_hist  [NB][DEPTH];
    int unsigned m_ptr   [NB];
    int unsigned m_cnt   [NB];

    task automatic chk(input string req, input string what, input int unsigned act, input int unsigned exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic void model_prog(input int b, input int unsigned now);
        if (m_seen[b]) begin
            m_hist[b][m_ptr[b]] = (now - m_stamp[b]) & MASK;
            m_ptr[b] = (m_ptr[b] + 1) % DEPTH;
            if (m_cnt[b] < DEPTH) m_cnt[b]++;
        end
        m_stamp[b] = now;
        m_seen[b]  = 1'b1;
        if (m_pec[b] < PMAX) m_pec[b]++;
    endfunction

    // One operation, then one idle cycle; response checked one cycle after the request
    task automatic op(input bit pv, input int pb, input bit rv, input int rb, input int unsigned now, input string tag);
        int unsigned e_age, e_mean, e_sum;
        @(negedge clk);
        prog_valid = pv; prog_blk = IDX_W'(pb);
        rd_valid = rv;   rd_blk = IDX_W'(rb);
        now_ts = TS_W'(now);
        if (pv) model_prog(pb, now);
        e_age = m_seen[rb] ? ((now - m_stamp[rb]) & MASK) : 0;
        e_sum = 0;
        for (int i = 0; i < int'(m_cnt[rb]); i++) e_sum += m_hist[rb][i];
        e_mean = (m_cnt[rb] == 0) ? 0 : e_sum / m_cnt[rb];
        @(negedge clk);
        prog_valid = 1'b0; rd_valid = 1'b0;
        chk("R2", {tag, " rsp_valid"}, 32'(rsp_valid), 32'(rv));
        if (rv) begin
            chk("R3", {tag, " age"}, 32'(rsp_age), e_age);
            chk("R4", {tag, " pec"}, 32'(rsp_pec), m_pec[rb]);
            chk("R7", {tag, " dwell count"}, 32'(rsp_dwell_cnt), m_cnt[rb]);
            chk("R8", {tag, " dwell mean"}, 32'(rsp_dwell_mean), e_mean);
        end
    endtask

    typedef struct packed {
        logic        pv;
        logic [2:0]  pb;
        logic        rv;
        logic [2:0]  rb;
        logic [15:0] now;
    } vec_t;

    // Stimulus table; expected responses come from the reference model
    localparam vec_t VEC [12] = '{
        '{1'b0, 3'd0, 1'b1, 3'd4, 16'd50},    // R1 unprogrammed block
        '{1'b1, 3'd0, 1'b0, 3'd0, 16'd100},
        '{1'b1, 3'd1, 1'b0, 3'd0, 16'd150},
        '{1'b0, 3'd0, 1'b1, 3'd0, 16'd160},   // R5 one program, no sample
        '{1'b1, 3'd0, 1'b0, 3'd0, 16'd300},   // R6 gap 200
        '{1'b0, 3'd0, 1'b1, 3'd0, 16'd310},
        '{1'b1, 3'd0, 1'b0, 3'd0, 16'd700},   // R6 gap 400
        '{1'b0, 3'd0, 1'b1, 3'd0, 16'd705},   // R8 mean 300
        '{1'b0, 3'd0, 1'b1, 3'd1, 16'd800},   // R10 block 1 untouched
        '{1'b1, 3'd2, 1'b1, 3'd1, 16'd1000},  // R10 program 2, read 1
        '{1'b1, 3'd1, 1'b1, 3'd2, 16'd1100},  // R10 program 1, read 2
        '{1'b0, 3'd0, 1'b1, 3'd7, 16'd1200}   // R1 still unprogrammed
    };

    initial begin
        for (int b = 0; b < NB; b++) begin
            m_stamp[b] = 0; m_pec[b] = 0; m_seen[b] = 0; m_ptr[b] = 0; m_cnt[b] = 0;
            for (int i = 0; i < DEPTH; i++) m_hist[b][i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "rsp_valid after reset", 32'(rsp_valid), 0);
        chk("R1", "age after reset", 32'(rsp_age), 0);

        foreach (VEC[k]) begin
            op(VEC[k].pv, int'(VEC[k].pb), VEC[k].rv, int'(VEC[k].rb), 32'(VEC[k].now), "table");
        end

        // R3 and R6 across a counter wrap
        op(1'b1, 3, 1'b0, 3, 32'hFFF0, "wrap prog1");
        op(1'b1, 3, 1'b0, 3, 32'h0010, "wrap prog2");
        op(1'b0, 3, 1'b1, 3, 32'h0018, "R3 R6 wrap read");
        chk("R6", "wrapped gap sample", 32'(rsp_dwell_mean), 32);

        // R7 ring overwrite and R4 saturation on block 5
        begin
            int unsigned t = 2000;
            for (int k = 0; k < 40; k++) begin
                t = t + 3 * k + 1;
                op(1'b1, 5, 1'b0, 5, t, "fill");
                if (k == 21) op(1'b0, 5, 1'b1, 5, t + 7, "R7 past full");
            end
            op(1'b0, 5, 1'b1, 5, t + 9, "R4 R7 saturated");
            chk("R4", "saturated pec", 32'(rsp_pec), PMAX);
            chk("R7", "count held at depth", 32'(rsp_dwell_cnt), DEPTH);
        end

        // R9 program and read of one block in the same cycle
        op(1'b1, 0, 1'b1, 0, 32'd5000, "R9 same block");
        chk("R9", "same-cycle age", 32'(rsp_age), 0);
        op(1'b1, 5, 1'b1, 5, 32'd9000, "R9 full ring same block");

        // R2 idle cycle gives no response
        op(1'b0, 0, 1'b0, 0, 32'd9100, "R2 idle");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule